// File: doc/BRIEF.md
# Pulse-Width Serial Message Transmitter

This block places one ten-bit message on a two-wire differential bus whose bit values are carried by the length of the interval between edges. A host raises a request with a 3-bit address and a 5-bit data value. The block computes a 2-bit check value over these fields. It then drives a long active start pulse, followed by ten intervals whose bus level alternates on each bit. It ends by leaving the bus passive. The two output wires are always opposite in level.

Interval lengths are cycle-count parameters. The short and long symbols must match the windows the receivers use, and the start pulse must be the longest symbol. The same level-dependent mapping applies on both sides of the bus. On a passive interval, a one is long and a zero is short. On an active interval, a one is short and a zero is long. This keeps the average bit time close to fixed. With the default counts and a 200 MHz clock, the rate is about 3.3 kbit/s.

The host handshake is a request strobe with busy and done indications. Requests made while a message is in progress are discarded.

Top module: `vpw_msg_tx`

## Requirements
- R1: During and after reset, and whenever no message is in progress, `bus_pos` is 0 (passive), `busy` is 0 and `done` is 0.
- R2: A request seen on a clock edge while `busy` is 0 makes `busy` 1 and `bus_pos` 1 (active) from the next cycle. The bus stays active for exactly `SOM_CYC` cycles.
- R3: After the start pulse, ten intervals follow. Their levels alternate, starting with passive, so the tenth interval is active.
- R4: An interval lasts `LONG_CYC` cycles when the bit value XOR the level is 1, where active counts as 1. Otherwise it lasts `SHORT_CYC` cycles.
- R5: The ten bits are sent in this order: address bits 2 down to 0, data bits 4 down to 0, then check bits 1 down to 0.
- R6: The check value is the bitwise inverse of the two least significant bits of the number of ones in the eight address and data bits.
- R7: `bus_neg` is always the logical inverse of `bus_pos`.
- R8: After the tenth interval, the bus is passive for `LONG_CYC` cycles with `busy` still 1. In the following cycle, `done` is 1 for one cycle and `busy` is 0. A request in that cycle is accepted.
- R9: A request made while `busy` is 1 is ignored. Changes to `addr` or `data` while busy do not alter the message in flight. When the message ends, the bus stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Send request, sampled when idle |
| addr | input | 3 | Address field of the message |
| data | input | 5 | Data field of the message |
| busy | output | 1 | Message in progress |
| done | output | 1 | One-cycle pulse when the message has completed |
| bus_pos | output | 1 | Bus wire, 1 = active |
| bus_neg | output | 1 | Complementary bus wire |

## Verification
The bench builds the block with `SHORT_CYC=3`, `LONG_CYC=6` and `SOM_CYC=9`. With these values a full message lasts about sixty cycles, so many address and data patterns fit in one short run. The values include all-zero and all-one fields and each possible check value. The three symbol lengths differ from one another, so a wrong bit mapping, a wrong level order or a start pulse cut short shows up as a mismatch in a specific cycle. The short frames also allow a request to be held continuously from one message into the next, so the acceptance in the done cycle is exercised. Requests injected mid-frame exercise the discard path.

// File: rtl/vpw_pkg.sv
package vpw_pkg;

    localparam int ADDR_W  = 3;
    localparam int DATA_W  = 5;
    localparam int CHK_W   = 2;
    localparam int PAY_W   = ADDR_W + DATA_W;
    localparam int FRAME_W = PAY_W + CHK_W;
    localparam int IDX_W   = $clog2(FRAME_W);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_BITS,
        ST_TAIL
    } tx_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [CHK_W-1:0]  chk;
    } frame_t;

    // Inverted low bits of the population count over address and data
    function automatic logic [CHK_W-1:0] check_of(input logic [PAY_W-1:0] payload);
        logic [IDX_W:0] ones;
        ones = '0;
        for (int i = 0; i < PAY_W; i++) begin
            ones = ones + (IDX_W+1)'(payload[i]);
        end
        return ~ones[CHK_W-1:0];
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/vpw_frame_build.sv
module vpw_frame_build
    import vpw_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output frame_t            frame
);
    always_comb begin
        frame.addr = addr;
        frame.data = data;
        frame.chk  = check_of({addr, data});
    end
endmodule

// File: rtl/vpw_symbol_len.sv
module vpw_symbol_len #(
    parameter int SHORT_CYC = 3,
    parameter int LONG_CYC  = 6,
    parameter int CNT_W     = 4
) (
    input  logic             bit_val,
    input  logic             level_active,
    output logic [CNT_W-1:0] len_m1
);
    localparam logic [CNT_W-1:0] SHORT_M1 = CNT_W'(SHORT_CYC - 1);
    localparam logic [CNT_W-1:0] LONG_M1  = CNT_W'(LONG_CYC - 1);

    // Passive: one is long. Active: zero is long.
    always_comb begin
        len_m1 = (bit_val ^ level_active) ? LONG_M1 : SHORT_M1;
    end
endmodule

// File: rtl/vpw_interval_timer.sv
module vpw_interval_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/vpw_msg_tx.sv
module vpw_msg_tx
    import vpw_pkg::*;
#(
    parameter int SHORT_CYC = 40000,
    parameter int LONG_CYC  = 80000,
    parameter int SOM_CYC   = 120000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic              busy,
    output logic              done,
    output logic              bus_pos,
    output logic              bus_neg
);
    localparam int MAX_CYC = max3(SHORT_CYC, LONG_CYC, SOM_CYC);
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] SOM_M1  = CNT_W'(SOM_CYC - 1);
    localparam logic [CNT_W-1:0] LONG_M1 = CNT_W'(LONG_CYC - 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_W - 1);

    tx_state_e          state_q;
    logic [FRAME_W-1:0] shreg_q;
    logic [IDX_W-1:0]   idx_q;
    logic               act_q;
    logic               inv_q;
    logic               done_q;

    frame_t             frame_in;
    logic               tmr_load;
    logic [CNT_W-1:0]   tmr_val;
    logic               tmr_zero;
    logic               sym_bit;
    logic               sym_lvl;
    logic [CNT_W-1:0]   sym_len;

    vpw_frame_build u_build (
        .addr  (addr),
        .data  (data),
        .frame (frame_in)
    );

    vpw_symbol_len #(
        .SHORT_CYC (SHORT_CYC),
        .LONG_CYC  (LONG_CYC),
        .CNT_W     (CNT_W)
    ) u_len (
        .bit_val      (sym_bit),
        .level_active (sym_lvl),
        .len_m1       (sym_len)
    );

    vpw_interval_timer #(
        .CNT_W (CNT_W)
    ) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_zero)
    );

    // Timer reload selection
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        sym_bit  = shreg_q[FRAME_W-1];
        sym_lvl  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req) begin
                    tmr_load = 1'b1;
                    tmr_val  = SOM_M1;
                end
            end
            ST_START: begin
                if (tmr_zero) begin
                    tmr_load = 1'b1;
                    sym_bit  = shreg_q[FRAME_W-1];
                    sym_lvl  = 1'b0;
                    tmr_val  = sym_len;
                end
            end
            ST_BITS: begin
                if (tmr_zero) begin
                    tmr_load = 1'b1;
                    if (idx_q == LAST_IDX) begin
                        tmr_val = LONG_M1;
                    end else begin
                        sym_bit = shreg_q[FRAME_W-2];
                        sym_lvl = ~act_q;
                        tmr_val = sym_len;
                    end
                end
            end
            default: begin
            end
        endcase
    end

    // Sequencer and output registers
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            shreg_q <= '0;
            idx_q   <= '0;
            act_q   <= 1'b0;
            inv_q   <= 1'b1;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (req) begin
                        shreg_q <= frame_in;
                        state_q <= ST_START;
                        act_q   <= 1'b1;
                        inv_q   <= 1'b0;
                    end
                end
                ST_START: begin
                    if (tmr_zero) begin
                        state_q <= ST_BITS;
                        idx_q   <= '0;
                        act_q   <= 1'b0;
                        inv_q   <= 1'b1;
                    end
                end
                ST_BITS: begin
                    if (tmr_zero) begin
                        if (idx_q == LAST_IDX) begin
                            state_q <= ST_TAIL;
                            act_q   <= 1'b0;
                            inv_q   <= 1'b1;
                        end else begin
                            idx_q   <= idx_q + 1'b1;
                            shreg_q <= {shreg_q[FRAME_W-2:0], 1'b0};
                            act_q   <= ~act_q;
                            inv_q   <= act_q;
                        end
                    end
                end
                ST_TAIL: begin
                    if (tmr_zero) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy    = (state_q != ST_IDLE);
    assign done    = done_q;
    assign bus_pos = act_q;
    assign bus_neg = inv_q;
endmodule

// File: rtl/vpw_msg_tx_chk.sv
module vpw_msg_tx_chk (
    input logic clk,
    input logic rst,
    input logic req,
    input logic busy,
    input logic done,
    input logic bus_pos,
    input logic bus_neg
);
    assert_wires_opposite_R7: assert property (@(posedge clk) disable iff (rst)
        bus_neg == ~bus_pos);

    assert_idle_passive_R1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !bus_pos);

    assert_accept_start_R2: assert property (@(posedge clk) disable iff (rst)
        (!busy && req) |=> (busy && bus_pos));

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && !bus_pos));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_end_signals_done_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    assert_no_start_without_req_R9: assert property (@(posedge clk) disable iff (rst)
        (!busy && !req) |=> !busy);
endmodule

bind vpw_msg_tx vpw_msg_tx_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .req     (req),
    .busy    (busy),
    .done    (done),
    .bus_pos (bus_pos),
    .bus_neg (bus_neg)
);

// File: tb/vpw_msg_tx_test.sv
`timescale 1ns/1ps
module vpw_msg_tx_test;
    localparam int SHORT = 3;
    localparam int LONG  = 6;
    localparam int SOM   = 9;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req = 1'b0;
    logic [2:0] addr = '0;
    logic [4:0] data = '0;
    logic       busy, done, bus_pos, bus_neg;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    typedef struct {
        bit    bus;
        bit    bsy;
        bit    dn;
        string tag;
    } slot_t;

    slot_t q[$];
    slot_t exp_s;

    always #2.5 clk = ~clk;

    vpw_msg_tx #(.SHORT_CYC(SHORT), .LONG_CYC(LONG), .SOM_CYC(SOM)) uut (
        .clk(clk), .rst(rst), .req(req), .addr(addr), .data(data),
        .busy(busy), .done(done), .bus_pos(bus_pos), .bus_neg(bus_neg)
    );

    task automatic add(input bit b, input bit by, input bit d, input string t, input int n);
        slot_t s;
        s.bus = b; s.bsy = by; s.dn = d; s.tag = t;
        for (int i = 0; i < n; i++) q.push_back(s);
    endtask

    // Behavioural expectation: one queue entry per cycle of the message
    task automatic plan_msg(input logic [2:0] a, input logic [4:0] d);
        bit bits[10];
        int ones;
        bit lvl;
        ones = 0;
        for (int i = 0; i < 3; i++) ones += a[i];
        for (int i = 0; i < 5; i++) ones += d[i];
        for (int i = 0; i < 3; i++) bits[i] = a[2-i];
        for (int i = 0; i < 5; i++) bits[3+i] = d[4-i];
        bits[8] = ~ones[1];          // R6 check value, MSB first
        bits[9] = ~ones[0];
        add(1, 1, 0, "R2 start", SOM);
        lvl = 0;                      // R3 passive first
        for (int i = 0; i < 10; i++) begin
            add(lvl, 1, 0, (i < 8) ? "R3 R4 R5 bit" : "R3 R4 R6 check",
                (bits[i] ^ lvl) ? LONG : SHORT);
            lvl = ~lvl;
        end
        add(0, 1, 0, "R8 tail", LONG);
        add(0, 0, 1, "R8 done", 1);
    endtask

    always @(posedge clk) begin
        if (rst) begin
            q.delete();
            exp_s.bus = 0; exp_s.bsy = 0; exp_s.dn = 0; exp_s.tag = "R1 idle";
        end else begin
            if (q.size() == 0 && req) plan_msg(addr, data);
            if (q.size() > 0) exp_s = q.pop_front();
            else begin
                exp_s.bus = 0; exp_s.bsy = 0; exp_s.dn = 0; exp_s.tag = "R1 idle";
            end
        end
    end

    task automatic chk(input bit act, input bit expv, input string what);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: actual=%0b expected=%0b at %0t", what, act, expv, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !ended) begin
            chk(bus_pos, exp_s.bus, {exp_s.tag, " bus_pos"});
            chk(busy, exp_s.bsy, "R2 busy");
            chk(done, exp_s.dn, "R8 done");
            chk(bus_neg, ~bus_pos, "R7 bus_neg");
        end
    end

    task automatic summary();
        ended = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    task automatic wait_done();
        while (done !== 1'b1) @(negedge clk);
    endtask

    task automatic send(input logic [2:0] a, input logic [4:0] d);
        @(negedge clk);
        req = 1; addr = a; data = d;
        @(negedge clk);
        req = 0;
        wait_done();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(bus_pos, 0, "R1 reset bus_pos");
        chk(bus_neg, 1, "R1 reset bus_neg");
        chk(busy, 0, "R1 reset busy");
        chk(done, 0, "R1 reset done");
        rst = 0;
        repeat (2) @(negedge clk);

        send(3'd0, 5'd0);
        send(3'd7, 5'd31);
        send(3'd5, 5'h15);
        send(3'd2, 5'h0A);
        send(3'd6, 5'h13);
        send(3'd1, 5'h01);

        // R9: requests and field changes mid-message are dropped
        @(negedge clk);
        req = 1; addr = 3'd1; data = 5'h11;
        @(negedge clk);
        req = 0;
        repeat (5) @(negedge clk);
        req = 1; addr = 3'd4; data = 5'h1E;
        repeat (2) @(negedge clk);
        req = 0;
        addr = 3'd7; data = 5'h00;
        wait_done();
        repeat (4) begin
            @(negedge clk);
            chk(busy, 0, "R9 stays idle busy");
            chk(bus_pos, 0, "R9 stays idle bus_pos");
        end

        // R8: request held through done is accepted at once
        req = 1; addr = 3'd3; data = 5'h07;
        @(negedge clk);
        wait_done();
        addr = 3'd1; data = 5'h1C;
        @(negedge clk);
        req = 0;
        wait_done();
        repeat (5) @(negedge clk);
        summary();
    end
endmodule